// File: doc/BRIEF.md
# Two-Wire Control Register Slave for a Clock Synthesizer

This block is the serial control port of a clock synthesizer. It answers on a two-wire serial bus and holds sixteen 8-bit control registers. Their contents are presented on a parallel bus that drives the synthesizer's output enables, frequency selection and divider settings. A host can write or read one register at a time, or stream the whole register file in a single block transfer.

The block keeps each register's reset default and hides the read-only fields behind fixed values. It also captures the four frequency-select strap pins once after power-on reset and shows them in read-only bits. SCL and SDA are oversampled on the system clock through two-stage synchronizers. SDA is only ever pulled low, through an output-enable pin that drives an open-drain pad.

Top module: `clkgen_i2c_regs`

## Requirements
- R1: The slave acknowledges the address byte 0xD2 (write) or 0xD3 (read), that is the 7-bit address 0x69. Any other address gets no acknowledge, and every following byte is ignored until the next START.
- R2: A command byte with bit 7 set selects byte mode on register cmd[3:0]. In a write, the first data byte goes to that register and later bytes are acknowledged and discarded. In a read, the slave returns that register and then 0xFF for any further byte.
- R3: The command byte 0x00 selects block mode. The next byte is a count, which is acknowledged and whose value is ignored. Data bytes then fill register 0, 1, 2 and upward. Bytes past register 15 are acknowledged and discarded.
- R4: A block-mode read returns the count 16 first, then registers 0 to 15 in order, then 0xFF.
- R5: After reset, registers 0..15 read 40,(see R7),FF,FF,F0,88,90,BB,72,50,04,0E,88,0F,2C,E4 (hex).
- R6: Register 8 always reads 0x72 and register 9 always reads 0x50. Writes to either have no effect.
- R7: In register 1, bits 7:5 are writable with reset value 011. Bit 4 always reads 0. Bits 3:0 hold the captured straps, with strap pin n in bit n.
- R8: The straps are sampled on the first clock after power-on reset is released and are never sampled again until the next reset.
- R9: A nonzero command byte with bit 7 clear is not acknowledged, and the transfer is abandoned.
- R10: When the master NACKs a byte during a read, the slave stops transmitting and leaves SDA released.
- R11: A repeated START restarts address decoding. A read keeps the last selected mode and register. After reset the mode is block.
- R12: SDA is only pulled low through sda_oe. sda_oe changes only while the synchronized SCL is low, and it is low after a STOP.
- R13: regs_o always carries the visible value of every register, with register n in bits 8n+7:8n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| por_n | input | 1 | Power-on reset, active low |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low |
| strap_i | input | 4 | Frequency-select strap pins |
| regs_o | output | 128 | Visible register image, register n at bits 8n+7:8n |

## Verification
A bus write to register 1 and the read-only strap and zero bits meet in the same register, so the same update both takes the host's data and keeps the captured straps. The bench writes 0xFF there and expects 0xEA. It then changes the strap pins and expects no change. Two events also coincide in one cycle: the last in-range block-write byte being stored, and the pointer reaching its end stop. The bench sends 18 data bytes and judges that all 18 are acknowledged, that registers 0..15 take the first 16 bytes, and that the image stays equal to its reference model on every clock.

// File: rtl/clkgen_i2c_regs.sv
module clkgen_i2c_regs #(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int NREG = 16,
  parameter int STRAPS = 4,
  parameter int STRAP_REG = 1,
  parameter int ID_REG = 8,
  parameter int RSV_REG = 9,
  parameter logic [NREG*8-1:0] RST_IMAGE = 128'hE42C_0F88_0E04_5072_BB90_88F0_FFFF_6840
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [STRAPS-1:0] strap_i,
  output logic [NREG*8-1:0] regs_o
);
  localparam int IW = $clog2(NREG);
  localparam int PW = $clog2(NREG + 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_CMD, S_CNT, S_WDATA, S_RDATA} st_t;

  logic [2:0] scl_sy, sda_sy;
  logic       rise, fall, start, stop;
  st_t        st, nst;
  logic       ack_ph, got_ack, blk, done, strap_done;
  logic [3:0] bcnt;
  logic [7:0] sh, tx, nxt, first_b;
  logic [IW-1:0] idx;
  logic [PW-1:0] ptr;
  logic [STRAPS-1:0] strap_q;
  logic [7:0] mem  [NREG];
  logic [7:0] view [NREG];

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      scl_sy <= '1;
      sda_sy <= '1;
    end else begin
      scl_sy <= {scl_sy[1:0], scl_i};
      sda_sy <= {sda_sy[1:0], sda_i};
    end

  assign rise  =  scl_sy[1] & ~scl_sy[2];
  assign fall  = ~scl_sy[1] &  scl_sy[2];
  assign start =  scl_sy[1] &  scl_sy[2] & ~sda_sy[1] &  sda_sy[2];
  assign stop  =  scl_sy[1] &  scl_sy[2] &  sda_sy[1] & ~sda_sy[2];

  always_comb begin
    for (int i = 0; i < NREG; i++) view[i] = mem[i];
    view[STRAP_REG] = {mem[STRAP_REG][7:STRAPS+1], 1'b0, strap_q};
    view[ID_REG]    = RST_IMAGE[ID_REG*8 +: 8];
    view[RSV_REG]   = RST_IMAGE[RSV_REG*8 +: 8];
  end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign regs_o[g*8 +: 8] = view[g];
  end

  assign nxt     = (blk && ptr < PW'(NREG)) ? view[ptr[IW-1:0]] : 8'hFF;
  assign first_b = blk ? 8'(NREG) : view[idx];

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= RST_IMAGE[i*8 +: 8];
      strap_q    <= '0;
      strap_done <= 1'b0;
      st         <= S_IDLE;
      nst        <= S_IDLE;
      ack_ph     <= 1'b0;
      got_ack    <= 1'b0;
      blk        <= 1'b1;
      done       <= 1'b0;
      bcnt       <= '0;
      sh         <= '0;
      tx         <= '1;
      idx        <= '0;
      ptr        <= '0;
      sda_oe     <= 1'b0;
    end else begin
      if (!strap_done) begin
        strap_q    <= strap_i;
        strap_done <= 1'b1;
      end
      if (start) begin
        st     <= S_ADDR;
        ack_ph <= 1'b0;
        bcnt   <= '0;
        sda_oe <= 1'b0;
      end else if (stop) begin
        st     <= S_IDLE;
        ack_ph <= 1'b0;
        sda_oe <= 1'b0;
      end else if (st == S_RDATA) begin
        if (!ack_ph) begin
          if (fall) begin
            if (bcnt == 4'd8) begin
              sda_oe <= 1'b0;
              ack_ph <= 1'b1;
            end else begin
              sda_oe <= ~tx[6];
              tx     <= {tx[6:0], 1'b1};
              bcnt   <= bcnt + 4'd1;
            end
          end
        end else begin
          if (rise) got_ack <= ~sda_sy[1];
          if (fall) begin
            if (got_ack) begin
              tx     <= nxt;
              sda_oe <= ~nxt[7];
              bcnt   <= 4'd1;
              ack_ph <= 1'b0;
              if (ptr < PW'(NREG)) ptr <= ptr + PW'(1);
            end else begin
              st     <= S_IDLE;
              ack_ph <= 1'b0;
            end
          end
        end
      end else if (st != S_IDLE) begin
        if (!ack_ph) begin
          if (rise && bcnt != 4'd8) begin
            sh   <= {sh[6:0], sda_sy[1]};
            bcnt <= bcnt + 4'd1;
          end
          if (fall && bcnt == 4'd8) begin
            ack_ph <= 1'b1;
            unique case (st)
              S_ADDR:
                if (sh[7:1] == DEV_ADDR) begin
                  sda_oe <= 1'b1;
                  nst    <= sh[0] ? S_RDATA : S_CMD;
                end else begin
                  st     <= S_IDLE;
                  ack_ph <= 1'b0;
                end
              S_CMD:
                if (sh == 8'h00) begin
                  blk    <= 1'b1;
                  sda_oe <= 1'b1;
                  nst    <= S_CNT;
                end else if (sh[7]) begin
                  blk    <= 1'b0;
                  idx    <= sh[IW-1:0];
                  done   <= 1'b0;
                  sda_oe <= 1'b1;
                  nst    <= S_WDATA;
                end else begin
                  st     <= S_IDLE;
                  ack_ph <= 1'b0;
                end
              S_CNT: begin
                ptr    <= '0;
                sda_oe <= 1'b1;
                nst    <= S_WDATA;
              end
              default: begin
                sda_oe <= 1'b1;
                nst    <= S_WDATA;
                if (blk) begin
                  if (ptr < PW'(NREG)) begin
                    mem[ptr[IW-1:0]] <= sh;
                    ptr <= ptr + PW'(1);
                  end
                end else if (!done) begin
                  mem[idx] <= sh;
                  done     <= 1'b1;
                end
              end
            endcase
          end
        end else if (fall) begin
          ack_ph <= 1'b0;
          st     <= nst;
          if (nst == S_RDATA) begin
            tx     <= first_b;
            sda_oe <= ~first_b[7];
            bcnt   <= 4'd1;
            ptr    <= '0;
          end else begin
            sda_oe <= 1'b0;
            bcnt   <= '0;
          end
        end
      end
    end
endmodule

// File: rtl/clkgen_i2c_regs_chk.sv
module clkgen_i2c_regs_chk #(
  parameter int NREG = 16,
  parameter int STRAPS = 4,
  parameter int PW = 5
) (
  input logic              clk,
  input logic              por_n,
  input logic              sda_oe,
  input logic [NREG*8-1:0] regs_o,
  input logic              scl_s,
  input logic              stop_evt,
  input logic              idle,
  input logic [PW-1:0]     ptr,
  input logic              strap_done
);
  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!por_n)
    $changed(sda_oe) |-> !$past(scl_s)); // R12
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!por_n)
    stop_evt |=> !sda_oe); // R12
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!por_n)
    idle |-> !sda_oe); // R1
  AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!por_n)
    ptr <= PW'(NREG)); // R3
  AST_STRAP_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    (strap_done && $past(strap_done)) |-> $stable(regs_o[8 +: STRAPS])); // R8
  AST_WRITE_ON_ACK: assert property (@(posedge clk) disable iff (!por_n)
    (strap_done && $past(strap_done) && $changed(regs_o)) |-> $rose(sda_oe)); // R2
endmodule

bind clkgen_i2c_regs clkgen_i2c_regs_chk #(.NREG(NREG), .STRAPS(STRAPS), .PW(PW)) u_chk (
  .clk(clk), .por_n(por_n), .sda_oe(sda_oe), .regs_o(regs_o),
  .scl_s(scl_sy[1]), .stop_evt(stop), .idle(st == S_IDLE),
  .ptr(ptr), .strap_done(strap_done)
);

// File: tb/tb_clkgen_i2c_regs.sv
`timescale 1ns/1ps
module tb_clkgen_i2c_regs;
  localparam int Q = 8;
  logic clk = 0, por_n = 0;
  logic m_scl = 1, m_sda_lo = 0;
  logic [3:0] strap = 4'b1010;
  logic sda_oe;
  logic [127:0] regs_o;
  wire sda_line = ~(m_sda_lo | sda_oe);

  clkgen_i2c_regs dut (.clk(clk), .por_n(por_n), .scl_i(m_scl), .sda_i(sda_line),
                       .sda_oe(sda_oe), .strap_i(strap), .regs_o(regs_o));

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  logic hold = 1, run = 0;
  logic [7:0] exp_r [16];
  localparam logic [3:0] STRAP_CAP = 4'b1010;

  function automatic logic [127:0] image();
    logic [127:0] v;
    for (int i = 0; i < 16; i++) v[i*8 +: 8] = exp_r[i];
    return v;
  endfunction

  function automatic void model_write(int i, logic [7:0] v);
    if (i == 8 || i == 9) return;
    if (i == 1) exp_r[1] = {v[7:5], 1'b0, STRAP_CAP};
    else exp_r[i] = v;
  endfunction

  task automatic check(logic ok, string tag, logic [127:0] act, logic [127:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (run && !hold) check(regs_o === image(), "R13 register image", regs_o, image());
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      finish_up();
    end
  end

  task automatic w(int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start();
    m_sda_lo = 0; w(Q); m_scl = 1; w(Q); m_sda_lo = 1; w(Q); m_scl = 0; w(Q);
  endtask

  task automatic bus_stop();
    m_sda_lo = 1; w(Q); m_scl = 1; w(Q); m_sda_lo = 0; w(Q);
  endtask

  task automatic send_byte(logic [7:0] b, output logic ack);
    hold = 1;
    for (int k = 7; k >= 0; k--) begin
      m_sda_lo = ~b[k]; w(Q); m_scl = 1; w(Q); m_scl = 0; w(Q);
    end
    m_sda_lo = 0; w(Q); m_scl = 1; w(Q / 2);
    ack = (sda_line == 1'b0);
    w(Q / 2); m_scl = 0; w(Q);
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic give_ack);
    for (int k = 7; k >= 0; k--) begin
      m_sda_lo = 0; w(Q); m_scl = 1; w(Q / 2); b[k] = sda_line; w(Q / 2); m_scl = 0; w(Q);
    end
    m_sda_lo = give_ack; w(Q); m_scl = 1; w(Q); m_scl = 0; w(Q); m_sda_lo = 0;
  endtask

  task automatic byte_write(int i, logic [7:0] v, string tag);
    logic a;
    bus_start();
    send_byte(8'hD2, a); hold = 0;
    check(a, {tag, " address ack"}, a, 1);
    send_byte(8'h80 | 8'(i), a); hold = 0;
    check(a, {tag, " command ack"}, a, 1);
    send_byte(v, a); model_write(i, v); hold = 0;
    check(a, {tag, " data ack"}, a, 1);
    send_byte(~v, a); hold = 0;
    check(a, "R2 extra byte ack", a, 1);
    bus_stop();
  endtask

  task automatic byte_read(int i, output logic [7:0] v);
    logic a; logic [7:0] x;
    bus_start();
    send_byte(8'hD2, a); hold = 0;
    send_byte(8'h80 | 8'(i), a); hold = 0;
    bus_start();
    send_byte(8'hD3, a); hold = 0;
    check(a, "R11 read address ack after repeated START", a, 1);
    recv_byte(v, 1);
    recv_byte(x, 0);
    check(x == 8'hFF, "R2 byte after byte-mode read", x, 8'hFF);
    w(Q);
    check(!sda_oe, "R10 SDA released after NACK", sda_oe, 0);
    bus_stop();
  endtask

  initial begin
    logic a; logic [7:0] v;
    for (int i = 0; i < 16; i++) exp_r[i] = 8'(128'hE42C_0F88_0E04_5072_BB90_88F0_FFFF_6840 >> (i * 8));
    exp_r[1] = {3'b011, 1'b0, STRAP_CAP};
    w(5); por_n = 1; w(4);
    strap = 4'b0101;
    run = 1; hold = 0; w(2);
    check(regs_o === image(), "R5 reset image", regs_o, image());
    check(regs_o[15:8] == 8'h6A, "R7 strap bits in reg1", regs_o[15:8], 8'h6A);
    check(!sda_oe, "R12 idle bus not driven", sda_oe, 0);

    // R1 wrong address ignored
    bus_start();
    send_byte(8'hA0, a); hold = 0;
    check(!a, "R1 foreign address no ack", a, 0);
    send_byte(8'h83, a); hold = 0;
    check(!a, "R1 ignored after mismatch", a, 0);
    send_byte(8'h00, a); hold = 0;
    bus_stop();
    check(regs_o === image(), "R1 image unchanged", regs_o, image());

    // R2 byte mode
    byte_write(3, 8'h5A, "R2");
    byte_read(3, v);
    check(v == 8'h5A, "R2 byte read of reg3", v, 8'h5A);
    byte_read(0, v);
    check(v == 8'h40, "R5 byte read of reg0", v, 8'h40);

    // R6 fixed registers
    byte_write(8, 8'h00, "R6");
    byte_read(8, v);
    check(v == 8'h72, "R6 reg8 fixed", v, 8'h72);
    byte_write(9, 8'hFF, "R6");
    byte_read(9, v);
    check(v == 8'h50, "R6 reg9 fixed", v, 8'h50);

    // R7 / R8 reg1 mix of writable and read-only fields
    byte_write(1, 8'hFF, "R7");
    byte_read(1, v);
    check(v == 8'hEA, "R7 reg1 read-only fields", v, 8'hEA);
    strap = 4'b0011; w(20);
    byte_read(1, v);
    check(v == 8'hEA, "R8 straps not resampled", v, 8'hEA);

    // R9 illegal command
    bus_start();
    send_byte(8'hD2, a); hold = 0;
    send_byte(8'h05, a); hold = 0;
    check(!a, "R9 command NACK", a, 0);
    send_byte(8'h11, a); hold = 0;
    check(!a, "R9 transfer abandoned", a, 0);
    bus_stop();

    // R3 block write with overrun
    bus_start();
    send_byte(8'hD2, a); hold = 0;
    send_byte(8'h00, a); hold = 0;
    check(a, "R3 block command ack", a, 1);
    send_byte(8'd18, a); hold = 0;
    check(a, "R3 count ack", a, 1);
    for (int k = 0; k < 18; k++) begin
      send_byte(8'(8'h11 * k + 3), a);
      if (k < 16) model_write(k, 8'(8'h11 * k + 3));
      hold = 0;
      check(a, "R3 block data ack", a, 1);
    end
    bus_stop();
    check(regs_o === image(), "R3 block write image", regs_o, image());

    // R4 block read
    bus_start();
    send_byte(8'hD2, a); hold = 0;
    send_byte(8'h00, a); hold = 0;
    bus_start();
    send_byte(8'hD3, a); hold = 0;
    recv_byte(v, 1);
    check(v == 8'd16, "R4 byte count", v, 8'd16);
    for (int k = 0; k < 16; k++) begin
      recv_byte(v, 1);
      check(v == exp_r[k], "R4 block read data", v, exp_r[k]);
    end
    recv_byte(v, 0);
    check(v == 8'hFF, "R4 past end", v, 8'hFF);
    w(Q);
    check(!sda_oe, "R10 released after block NACK", sda_oe, 0);
    bus_stop();

    // R11 read without command keeps block mode; partial read ended early
    bus_start();
    send_byte(8'hD3, a); hold = 0;
    check(a, "R11 direct read ack", a, 1);
    recv_byte(v, 1);
    check(v == 8'd16, "R11 mode kept", v, 8'd16);
    recv_byte(v, 0);
    check(v == exp_r[0], "R10 first reg then NACK", v, exp_r[0]);
    w(Q);
    check(!sda_oe, "R10 no drive after NACK", sda_oe, 0);
    bus_stop();
    w(Q);
    check(!sda_oe, "R12 released after STOP", sda_oe, 0);

    w(10);
    finish_up();
  end
endmodule